// File: doc/BRIEF.md
# In-Order Commit Reorder Buffer

This block keeps the instructions that are in flight in program order inside a small circular queue. When an instruction is dispatched, the block takes the slot at the tail. It returns that slot's index, and this index is the rename tag for the instruction's result. Functional units later publish their results as (index, value) pairs. The value lands in the matching slot and never goes straight to the architectural registers.

Each cycle the block looks at the oldest slot. If that slot has its result, the block hands the destination register, the value and the slot index to the register file, then frees the slot. If the oldest slot finished with an exception, the block drops every slot in the same cycle and writes nothing. Younger results therefore never reach architectural state ahead of an older instruction.

Top module: `retire_order_buffer`

## Requirements
- R1: After reset the buffer is empty (`buf_empty`=1), `alloc_ready`=1, `alloc_tag`=0, and `commit_en` and `flush` are both 0.
- R2: An accepted allocation (`alloc_req` and `alloc_ready` both high at a clock edge) takes slot `alloc_tag`. The next allocation gets the following index, counting modulo DEPTH.
- R3: When DEPTH slots are held, `alloc_ready` is 0. A request made while full takes no slot, so the tag handed out later does not move.
- R4: A result written with `wb_valid` is stored in slot `wb_tag`. It appears on the commit outputs only once that slot is the oldest one, even if the result arrived before an older slot's result.
- R5: In a cycle where the oldest slot holds a result with no exception, `commit_en`=1 and `commit_dest`, `commit_value` and `commit_tag` give that slot's register, value and index. The slot is freed at the clock edge, so at most one slot commits per cycle.
- R6: A result write to a slot that is not held is dropped. A slot allocated later still waits for its own result.
- R7: In a cycle where the oldest slot finished with `wb_excp`=1, `flush`=1, `commit_en`=0 and `alloc_ready`=0. After the edge the buffer is empty, the next tag is 0, and none of the dropped slots ever commits.
- R8: An allocation and a commit in the same cycle both take effect.
- R9: `buf_empty` is 1 exactly when no slot is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Dispatch wants a slot |
| alloc_dest | input | RW | Destination register of the dispatched instruction |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | IW | Index of the slot that would be taken (rename tag) |
| wb_valid | input | 1 | Result bus carries a result |
| wb_tag | input | IW | Slot index the result belongs to |
| wb_value | input | DW | Result value |
| wb_excp | input | 1 | The producing instruction raised an exception |
| commit_en | output | 1 | Register file write enable |
| commit_dest | output | RW | Register to write |
| commit_value | output | DW | Value to write |
| commit_tag | output | IW | Index being committed, for clearing a matching register tag |
| flush | output | 1 | Exception at the oldest slot; all slots are dropped |
| buf_empty | output | 1 | No slot is held |

## Verification
The assertions assume that dispatch honours `alloc_ready`. They also assume that each held slot receives at most one result, carried by the index it was given. The bench raises `alloc_req` during a full cycle only to show that the request is ignored. It sends exactly one result per held slot and sends one deliberate stray write to a free slot. Results are sent out of program order, and allocation is made to coincide with commit and with the wrap of the index.

// File: rtl/rob_pkg.sv
package rob_pkg;

  // What the oldest slot allows this cycle
  typedef enum logic [1:0] {
    HD_EMPTY  = 2'd0,
    HD_WAIT   = 2'd1,
    HD_RETIRE = 2'd2,
    HD_FLUSH  = 2'd3
  } head_act_e;

  function automatic int unsigned idx_bits(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          flush_i,
  output logic [IW-1:0] head_idx_o,
  output logic [IW-1:0] tail_idx_o,
  output logic          full_o,
  output logic          empty_o
);

  localparam int unsigned PW = IW + 1;

  logic [PW-1:0] head_q, head_d;
  logic [PW-1:0] tail_q, tail_d;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    if (flush_i) begin
      head_d = '0;
      tail_d = '0;
    end else begin
      if (pop_i)  head_d = head_q + PW'(1);
      if (push_i) tail_d = tail_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  assign head_idx_o = head_q[IW-1:0];
  assign tail_idx_o = tail_q[IW-1:0];
  assign empty_o    = (head_q == tail_q);
  assign full_o     = (head_q[IW-1:0] == tail_q[IW-1:0]) && (head_q[IW] != tail_q[IW]);

  // R3: occupancy never exceeds the number of slots
  a_r3_occupancy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (PW'(tail_q - head_q) <= PW'(DEPTH)));

  // R3: no slot is taken while full
  a_r3_tail_holds_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !flush_i) |=> $stable(tail_q));

  // R5: each commit moves the head by exactly one
  a_r5_head_steps_once: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !flush_i) |=> (head_q == PW'($past(head_q) + PW'(1))));

  // R7: a flush leaves the buffer empty
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> empty_o);

endmodule

// File: rtl/rob_entries.sv
module rob_entries #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IW    = 3,
  parameter int unsigned RW    = 5,
  parameter int unsigned DW    = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_en_i,
  input  logic [IW-1:0]             alloc_idx_i,
  input  logic [RW-1:0]             alloc_dest_i,
  input  logic                      wb_valid_i,
  input  logic [IW-1:0]             wb_idx_i,
  input  logic [DW-1:0]             wb_value_i,
  input  logic                      wb_excp_i,
  input  logic                      retire_en_i,
  input  logic [IW-1:0]             retire_idx_i,
  input  logic                      flush_i,
  output logic [DEPTH-1:0]          valid_o,
  output logic [DEPTH-1:0]          done_o,
  output logic [DEPTH-1:0]          excp_o,
  output logic [DEPTH-1:0][RW-1:0]  dest_o,
  output logic [DEPTH-1:0][DW-1:0]  value_o
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic          valid_q, valid_d;
    logic          done_q,  done_d;
    logic          excp_q,  excp_d;
    logic [RW-1:0] dest_q;
    logic [DW-1:0] value_q;
    logic          hit_alloc, hit_wb, hit_ret;

    assign hit_alloc = alloc_en_i  && (alloc_idx_i  == IW'(i));
    assign hit_wb    = wb_valid_i  && (wb_idx_i     == IW'(i)) && valid_q;
    assign hit_ret   = retire_en_i && (retire_idx_i == IW'(i));

    always_comb begin
      valid_d = valid_q;
      done_d  = done_q;
      excp_d  = excp_q;
      if (flush_i) begin
        valid_d = 1'b0;
        done_d  = 1'b0;
        excp_d  = 1'b0;
      end else begin
        if (hit_alloc) valid_d = 1'b1;
        if (hit_ret) begin
          valid_d = 1'b0;
          done_d  = 1'b0;
          excp_d  = 1'b0;
        end else if (hit_wb) begin
          done_d  = 1'b1;
          excp_d  = wb_excp_i;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= 1'b0;
        done_q  <= 1'b0;
        excp_q  <= 1'b0;
      end else begin
        valid_q <= valid_d;
        done_q  <= done_d;
        excp_q  <= excp_d;
      end
    end

    // datapath fields: loaded under enable, no reset
    always_ff @(posedge clk) begin
      if (hit_alloc) dest_q  <= alloc_dest_i;
      if (hit_wb)    value_q <= wb_value_i;
    end

    assign valid_o[i] = valid_q;
    assign done_o[i]  = done_q;
    assign excp_o[i]  = excp_q;
    assign dest_o[i]  = dest_q;
    assign value_o[i] = value_q;

    // R6: a result aimed at a free slot marks nothing complete
    a_r6_stray_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid_i && (wb_idx_i == IW'(i)) && !valid_q) |=> !done_q);
  end

endmodule

// File: rtl/rob_retire.sv
module rob_retire
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IW    = 3,
  parameter int unsigned RW    = 5,
  parameter int unsigned DW    = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [IW-1:0]             head_idx_i,
  input  logic                      empty_i,
  input  logic [DEPTH-1:0]          valid_i,
  input  logic [DEPTH-1:0]          done_i,
  input  logic [DEPTH-1:0]          excp_i,
  input  logic [DEPTH-1:0][RW-1:0]  dest_i,
  input  logic [DEPTH-1:0][DW-1:0]  value_i,
  output logic                      retire_o,
  output logic                      flush_o,
  output logic [RW-1:0]             dest_o,
  output logic [DW-1:0]             value_o,
  output logic [IW-1:0]             tag_o
);

  head_act_e act;

  always_comb begin
    if (empty_i || !valid_i[head_idx_i]) act = HD_EMPTY;
    else if (!done_i[head_idx_i])        act = HD_WAIT;
    else if (excp_i[head_idx_i])         act = HD_FLUSH;
    else                                 act = HD_RETIRE;
  end

  assign retire_o = (act == HD_RETIRE);
  assign flush_o  = (act == HD_FLUSH);
  assign dest_o   = retire_o ? dest_i[head_idx_i]  : '0;
  assign value_o  = retire_o ? value_i[head_idx_i] : '0;
  assign tag_o    = head_idx_i;

  // R7: a flush drops every slot, so it cannot repeat on the next cycle
  a_r7_flush_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> !flush_o);

  // R5: a committed slot is gone afterwards
  a_r5_slot_freed: assert property (@(posedge clk) disable iff (!rst_n)
    retire_o |=> !valid_i[$past(head_idx_i)]);

endmodule

// File: rtl/retire_order_buffer.sv
module retire_order_buffer
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned RW    = 5,
  parameter int unsigned DW    = 32,
  parameter int unsigned IW    = idx_bits(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_req,
  input  logic [RW-1:0] alloc_dest,
  output logic          alloc_ready,
  output logic [IW-1:0] alloc_tag,
  input  logic          wb_valid,
  input  logic [IW-1:0] wb_tag,
  input  logic [DW-1:0] wb_value,
  input  logic          wb_excp,
  output logic          commit_en,
  output logic [RW-1:0] commit_dest,
  output logic [DW-1:0] commit_value,
  output logic [IW-1:0] commit_tag,
  output logic          flush,
  output logic          buf_empty
);

  logic                     full, empty, accept, retire;
  logic [IW-1:0]            head_idx, tail_idx;
  logic [DEPTH-1:0]         s_valid, s_done, s_excp;
  logic [DEPTH-1:0][RW-1:0] s_dest;
  logic [DEPTH-1:0][DW-1:0] s_value;

  assign alloc_ready = !full && !flush;
  assign accept      = alloc_req && alloc_ready;
  assign alloc_tag   = tail_idx;
  assign buf_empty   = empty;
  assign commit_en   = retire;

  rob_ptrs #(.DEPTH(DEPTH), .IW(IW)) u_ptrs (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (accept),
    .pop_i      (retire),
    .flush_i    (flush),
    .head_idx_o (head_idx),
    .tail_idx_o (tail_idx),
    .full_o     (full),
    .empty_o    (empty)
  );

  rob_entries #(.DEPTH(DEPTH), .IW(IW), .RW(RW), .DW(DW)) u_entries (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_en_i   (accept),
    .alloc_idx_i  (tail_idx),
    .alloc_dest_i (alloc_dest),
    .wb_valid_i   (wb_valid),
    .wb_idx_i     (wb_tag),
    .wb_value_i   (wb_value),
    .wb_excp_i    (wb_excp),
    .retire_en_i  (retire),
    .retire_idx_i (head_idx),
    .flush_i      (flush),
    .valid_o      (s_valid),
    .done_o       (s_done),
    .excp_o       (s_excp),
    .dest_o       (s_dest),
    .value_o      (s_value)
  );

  rob_retire #(.DEPTH(DEPTH), .IW(IW), .RW(RW), .DW(DW)) u_retire (
    .clk        (clk),
    .rst_n      (rst_n),
    .head_idx_i (head_idx),
    .empty_i    (empty),
    .valid_i    (s_valid),
    .done_i     (s_done),
    .excp_i     (s_excp),
    .dest_i     (s_dest),
    .value_i    (s_value),
    .retire_o   (retire),
    .flush_o    (flush),
    .dest_o     (commit_dest),
    .value_o    (commit_value),
    .tag_o      (commit_tag)
  );

  // R9: refusing a slot without a flush means slots are held
  a_r9_refusal_implies_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_ready && !flush) |-> !buf_empty);

  // R8: accepting while committing keeps the slot count unchanged, so empty is unchanged
  a_r8_alloc_and_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && commit_en) |=> $stable(buf_empty));

endmodule

// File: tb/retire_order_buffer_bench.sv
module retire_order_buffer_bench;

  localparam int unsigned DEPTH = 4;
  localparam int unsigned RW    = 5;
  localparam int unsigned DW    = 16;
  localparam int unsigned IW    = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          alloc_req;
  logic [RW-1:0] alloc_dest;
  logic          alloc_ready;
  logic [IW-1:0] alloc_tag;
  logic          wb_valid;
  logic [IW-1:0] wb_tag;
  logic [DW-1:0] wb_value;
  logic          wb_excp;
  logic          commit_en;
  logic [RW-1:0] commit_dest;
  logic [DW-1:0] commit_value;
  logic [IW-1:0] commit_tag;
  logic          flush;
  logic          buf_empty;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  retire_order_buffer #(.DEPTH(DEPTH), .RW(RW), .DW(DW)) u_retire_order_buffer (
    .clk, .rst_n, .alloc_req, .alloc_dest, .alloc_ready, .alloc_tag,
    .wb_valid, .wb_tag, .wb_value, .wb_excp,
    .commit_en, .commit_dest, .commit_value, .commit_tag, .flush, .buf_empty
  );

  typedef struct packed {
    logic          a_req;
    logic [RW-1:0] a_dst;
    logic          w_v;
    logic [IW-1:0] w_tag;
    logic [DW-1:0] w_val;
    logic          w_exc;
    logic          e_rdy;
    logic [IW-1:0] e_tag;
    logic          e_cen;
    logic [RW-1:0] e_cdst;
    logic [DW-1:0] e_cval;
    logic [IW-1:0] e_ctag;
    logic          e_fl;
  } vec_t;

  // Outputs are compared in the cycle the inputs are driven, before the edge.
  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 5'd3, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 2'd0, 1'b0, 5'd0, 16'h0000, 2'd0, 1'b0},
    '{1'b1, 5'd5, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 2'd1, 1'b0, 5'd0, 16'h0000, 2'd0, 1'b0},
    '{1'b0, 5'd0, 1'b1, 2'd1, 16'h0022, 1'b0, 1'b1, 2'd2, 1'b0, 5'd0, 16'h0000, 2'd0, 1'b0},
    '{1'b0, 5'd0, 1'b1, 2'd0, 16'h0011, 1'b0, 1'b1, 2'd2, 1'b0, 5'd0, 16'h0000, 2'd0, 1'b0},
    '{1'b0, 5'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 2'd2, 1'b1, 5'd3, 16'h0011, 2'd0, 1'b0},
    '{1'b0, 5'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 2'd2, 1'b1, 5'd5, 16'h0022, 2'd1, 1'b0},
    '{1'b0, 5'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 2'd2, 1'b0, 5'd0, 16'h0000, 2'd0, 1'b0},
    '{1'b1, 5'd7, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 2'd2, 1'b0, 5'd0, 16'h0000, 2'd0, 1'b0},
    '{1'b1, 5'd8, 1'b1, 2'd2, 16'h0033, 1'b0, 1'b1, 2'd3, 1'b0, 5'd0, 16'h0000, 2'd0, 1'b0},
    '{1'b1, 5'd9, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 2'd0, 1'b1, 5'd7, 16'h0033, 2'd2, 1'b0},
    '{1'b0, 5'd0, 1'b1, 2'd0, 16'h0044, 1'b0, 1'b1, 2'd1, 1'b0, 5'd0, 16'h0000, 2'd0, 1'b0},
    '{1'b0, 5'd0, 1'b1, 2'd3, 16'h0055, 1'b0, 1'b1, 2'd1, 1'b0, 5'd0, 16'h0000, 2'd0, 1'b0},
    '{1'b0, 5'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 2'd1, 1'b1, 5'd8, 16'h0055, 2'd3, 1'b0},
    '{1'b0, 5'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 2'd1, 1'b1, 5'd9, 16'h0044, 2'd0, 1'b0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic a, input logic [RW-1:0] d, input logic wv,
                       input logic [IW-1:0] wt, input logic [DW-1:0] val, input logic ex);
    @(negedge clk);
    alloc_req  = a;
    alloc_dest = d;
    wb_valid   = wv;
    wb_tag     = wt;
    wb_value   = val;
    wb_excp    = ex;
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    alloc_req = 1'b0; alloc_dest = '0;
    wb_valid = 1'b0; wb_tag = '0; wb_value = '0; wb_excp = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1", "buf_empty",   int'(buf_empty),   1);
    chk("R1", "alloc_ready", int'(alloc_ready), 1);
    chk("R1", "alloc_tag",   int'(alloc_tag),   0);
    chk("R1", "commit_en",   int'(commit_en),   0);
    chk("R1", "flush",       int'(flush),       0);

    // Vector walk: out-of-order results, in-order commits, wrap (R2 R4 R5 R8 R9)
    for (int k = 0; k < NV; k++) begin
      drive(VEC[k].a_req, VEC[k].a_dst, VEC[k].w_v, VEC[k].w_tag, VEC[k].w_val, VEC[k].w_exc);
      chk("R9", "alloc_ready", int'(alloc_ready), int'(VEC[k].e_rdy));
      chk("R2", "alloc_tag",   int'(alloc_tag),   int'(VEC[k].e_tag));
      chk("R4", "commit_en",   int'(commit_en),   int'(VEC[k].e_cen));
      chk("R7", "flush",       int'(flush),       int'(VEC[k].e_fl));
      if (VEC[k].e_cen) begin
        chk("R5", "commit_dest",  int'(commit_dest),  int'(VEC[k].e_cdst));
        chk("R5", "commit_value", int'(commit_value), int'(VEC[k].e_cval));
        chk("R5", "commit_tag",   int'(commit_tag),   int'(VEC[k].e_ctag));
      end
    end
    // R9: everything committed
    drive(1'b0, 5'd0, 1'b0, 2'd0, 16'h0, 1'b0);
    chk("R9", "buf_empty", int'(buf_empty), 1);
    chk("R8", "alloc_tag after simultaneous alloc and commit", int'(alloc_tag), 1);

    // R6: stray write to free slot 2
    drive(1'b0, 5'd0, 1'b1, 2'd2, 16'h0099, 1'b0);
    // R3: fill all four slots
    drive(1'b1, 5'd1, 1'b0, 2'd0, 16'h0, 1'b0);
    chk("R2", "alloc_tag fill 1", int'(alloc_tag), 1);
    drive(1'b1, 5'd2, 1'b0, 2'd0, 16'h0, 1'b0);
    chk("R2", "alloc_tag fill 2", int'(alloc_tag), 2);
    drive(1'b1, 5'd3, 1'b0, 2'd0, 16'h0, 1'b0);
    chk("R2", "alloc_tag fill 3", int'(alloc_tag), 3);
    drive(1'b1, 5'd4, 1'b0, 2'd0, 16'h0, 1'b0);
    chk("R2", "alloc_tag fill 4", int'(alloc_tag), 0);
    // full: request is refused, result for slot 1 arrives
    drive(1'b1, 5'd31, 1'b1, 2'd1, 16'h000A, 1'b0);
    chk("R3", "alloc_ready when full", int'(alloc_ready), 0);
    chk("R3", "commit_en when head not done", int'(commit_en), 0);
    drive(1'b0, 5'd0, 1'b0, 2'd0, 16'h0, 1'b0);
    chk("R3", "alloc_ready still full", int'(alloc_ready), 0);
    chk("R5", "commit_en slot1", int'(commit_en), 1);
    chk("R5", "commit_dest slot1", int'(commit_dest), 1);
    chk("R5", "commit_value slot1", int'(commit_value), 16'h000A);
    chk("R5", "commit_tag slot1", int'(commit_tag), 1);
    drive(1'b0, 5'd0, 1'b0, 2'd0, 16'h0, 1'b0);
    chk("R6", "slot2 not completed by stray write", int'(commit_en), 0);
    chk("R3", "alloc_ready after commit", int'(alloc_ready), 1);
    chk("R3", "refused request took no slot", int'(alloc_tag), 1);

    // R7: exception reaches the head
    drive(1'b0, 5'd0, 1'b1, 2'd2, 16'h0, 1'b1);
    drive(1'b0, 5'd0, 1'b0, 2'd0, 16'h0, 1'b0);
    chk("R7", "flush", int'(flush), 1);
    chk("R7", "commit_en during flush", int'(commit_en), 0);
    chk("R7", "alloc_ready during flush", int'(alloc_ready), 0);
    drive(1'b1, 5'd6, 1'b0, 2'd0, 16'h0, 1'b0);
    chk("R7", "buf_empty after flush", int'(buf_empty), 1);
    chk("R7", "alloc_tag after flush", int'(alloc_tag), 0);
    chk("R7", "flush cleared", int'(flush), 0);
    chk("R7", "alloc_ready after flush", int'(alloc_ready), 1);
    drive(1'b0, 5'd0, 1'b1, 2'd0, 16'h0077, 1'b0);
    chk("R7", "no dropped slot commits", int'(commit_en), 0);
    drive(1'b0, 5'd0, 1'b0, 2'd0, 16'h0, 1'b0);
    chk("R7", "commit_en fresh slot", int'(commit_en), 1);
    chk("R7", "commit_dest fresh slot", int'(commit_dest), 6);
    chk("R7", "commit_value fresh slot", int'(commit_value), 16'h0077);
    chk("R7", "commit_tag fresh slot", int'(commit_tag), 0);
    drive(1'b0, 5'd0, 1'b0, 2'd0, 16'h0, 1'b0);
    chk("R9", "buf_empty at end", int'(buf_empty), 1);
    chk("R7", "stale slot 3 never commits", int'(commit_en), 0);

    finish_run();
  end

endmodule